// File: doc/BRIEF.md
# Link Repeater Capability Decoder and Limiter

This block sits between the capability-read step and the link-training controller of a DisplayPort source. When the six repeater capability bytes have been fetched from the sink, the controller pulses a strobe with the bytes and with the lane and rate limits of both sink and platform. The block decides whether link-training repeaters are present and valid and decodes how many there are. It then narrows the usable lane count and link rate to what the repeater chain supports.

Before training can start, the repeater mode register must be set. The block produces those register writes itself and hands them out one at a time on a request/acknowledge write port. A one-cycle done pulse marks the end of that short sequence. All results are registered and held until the next strobe.

Top module: `rptr_cap_limiter`

## Requirements
- R1: Repeaters count as present only when captured byte 0 (revision) is at least 0x14 and byte 2 (count field) is nonzero. Otherwise every captured byte on `cap_out` reads zero. Byte i sits at bits [8*i+7:8*i] of `cap_bytes` and of `cap_out`.
- R2: When present, a one-hot count field gives the repeater count on `rptr_count` as follows: 0x80=1, 0x40=2, 0x20=3, 0x10=4, 0x08=5, 0x04=6, 0x02=7, 0x01=8.
- R3: When present with a count field that is not one-hot, `rptr_count` is 0 and `warn` is 1. In every other case `warn` is 0.
- R4: When present, the first write is 0x55 (transparent) to address 0xF0003. If `rptr_count` is nonzero, a second write of 0xAA (non-transparent) follows to the same address. When not present, no write is issued.
- R5: `lane_cnt` is the smaller of the sink and platform lane limits. When `rptr_count` is nonzero and byte 4 is nonzero, it is further limited to byte 4.
- R6: The maximum rate code is the smaller of the sink and platform rate limits. When `rptr_count` is nonzero and byte 1 is nonzero, it is further limited to byte 1. `rate_code` is the highest of 0x14, 0x0A and 0x06 that does not exceed that maximum, or 0x00 if none does.
- R7: Only one write is presented at a time. `wr_req`, `wr_addr` and `wr_data` hold until `wr_ack` is seen high at a clock edge. `seq_done` pulses for one cycle, either one cycle after the last acknowledge or, when there are no writes, one cycle after the strobe. It is never high together with `wr_req`.
- R8: After reset all outputs are zero. Results appear in the cycle after the strobe edge and hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_valid | input | 1 | Strobe: capture bytes and limits |
| cap_bytes | input | 48 | Six capability bytes, byte 0 lowest |
| sink_lanes | input | 8 | Sink lane limit |
| plat_lanes | input | 8 | Platform lane limit |
| sink_rate | input | 8 | Sink maximum rate code |
| plat_rate | input | 8 | Platform maximum rate code |
| wr_ack | input | 1 | Acknowledge of the presented write |
| rptr_count | output | 4 | Decoded repeater count |
| lane_cnt | output | 8 | Clamped lane count |
| rate_code | output | 8 | Selected link rate code |
| warn | output | 1 | Bad count encoding seen |
| cap_out | output | 48 | Captured bytes, zeroed when absent |
| wr_req | output | 1 | Write request |
| wr_addr | output | 20 | Write address |
| wr_data | output | 8 | Write data |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench covers several boundary cases:
- A revision of exactly 0x13 against 0x14. An off-by-one comparison would start writes and keep bytes that must be cleared.
- A revision that qualifies but has a zero count field. A design that only checks the revision would issue a spurious transparent write.
- A multi-bit count field. This must give a count of zero, raise the warning, produce a single write and leave lanes and rate unclamped. A wrong decoder would let the repeater bytes narrow the link.

On the rate side, it tries maxima just above, just below and below every supported code, and zero repeater limits that must not clamp. It also stretches acknowledge latency to catch write data that changes before it is acknowledged.

// File: rtl/rptr_pkg.sv
// Shared constants and types for the repeater capability limiter.
// Assumes byte-wide capability fields and a 20-bit AUX address space.
package rptr_pkg;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 20;
    localparam logic [BYTE_W-1:0] MIN_REV     = 8'h14;
    localparam logic [ADDR_W-1:0] MODE_ADDR   = 20'hF0003;
    localparam logic [BYTE_W-1:0] MODE_TRANSP = 8'h55;
    localparam logic [BYTE_W-1:0] MODE_NONTR  = 8'hAA;
    localparam int NUM_RATES   = 3;
    // Supported rate codes, highest first (selection order matters).
    localparam logic [NUM_RATES*BYTE_W-1:0] RATE_LIST = {8'h06, 8'h0A, 8'h14};

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TRANS = 2'd1,
        SEQ_NONTR = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rptr_count_decode.sv
// Decodes presence and the one-hot repeater count field.
// Assumes MSB of the count field means one repeater, LSB means MAX_RPT.
module rptr_count_decode
    import rptr_pkg::*;
#(
    parameter int MAX_RPT = 8,
    parameter int CNT_W   = 4
) (
    input  logic [BYTE_W-1:0] rev_byte,
    input  logic [BYTE_W-1:0] cnt_byte,
    output logic              present,
    output logic [CNT_W-1:0]  count,
    output logic              bad_enc
);
    logic [MAX_RPT-1:0] hit;

    // One comparator per legal one-hot code.
    for (genvar i = 0; i < MAX_RPT; i++) begin : g_hit
        assign hit[i] = (cnt_byte == BYTE_W'(1 << (BYTE_W - 1 - i)));
    end

    // Presence test and count selection.
    always_comb begin
        present = (rev_byte >= MIN_REV) && (cnt_byte != '0);
        count   = '0;
        for (int i = 0; i < MAX_RPT; i++) begin
            if (present && hit[i]) count = CNT_W'(i + 1);
        end
        bad_enc = present && (hit == '0);
    end
endmodule

// File: rtl/rptr_link_clamp.sv
// Clamps lane count and maximum rate, then picks a supported rate code.
// Assumes repeater limits of zero mean "no limit reported".
module rptr_link_clamp
    import rptr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sink_lanes,
    input  logic [W-1:0] plat_lanes,
    input  logic [W-1:0] sink_rate,
    input  logic [W-1:0] plat_rate,
    input  logic         use_rptr,
    input  logic [W-1:0] rptr_lanes,
    input  logic [W-1:0] rptr_rate,
    output logic [W-1:0] lanes,
    output logic [W-1:0] rate_sel
);
    logic [W-1:0] base_lanes, base_rate, rate_max;

    // Base limits, then optional repeater limits.
    always_comb begin
        base_lanes = (sink_lanes < plat_lanes) ? sink_lanes : plat_lanes;
        base_rate  = (sink_rate < plat_rate) ? sink_rate : plat_rate;
        lanes      = base_lanes;
        rate_max   = base_rate;
        if (use_rptr && rptr_lanes != '0 && rptr_lanes < base_lanes) lanes = rptr_lanes;
        if (use_rptr && rptr_rate != '0 && rptr_rate < base_rate) rate_max = rptr_rate;
    end

    // Highest supported code not above the maximum; lowest index wins.
    always_comb begin
        rate_sel = '0;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (W'(RATE_LIST[i*BYTE_W +: BYTE_W]) <= rate_max)
                rate_sel = W'(RATE_LIST[i*BYTE_W +: BYTE_W]);
        end
    end
endmodule

// File: rtl/rptr_mode_seq.sv
// Issues the mode-register writes one by one on a req/ack port, then
// pulses done. A new load restarts the sequence from the beginning.
module rptr_mode_seq
    import rptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              need_trans,
    input  logic              need_nontr,
    input  logic              wr_ack,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              done
);
    seq_state_t state;
    logic       nontr_q;

    // Sequence state and remembered second-write need.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            nontr_q <= 1'b0;
        end else if (load) begin
            state   <= need_trans ? SEQ_TRANS : SEQ_DONE;
            nontr_q <= need_nontr;
        end else begin
            case (state)
                SEQ_TRANS: if (wr_ack) state <= nontr_q ? SEQ_NONTR : SEQ_DONE;
                SEQ_NONTR: if (wr_ack) state <= SEQ_DONE;
                SEQ_DONE:  state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    // Port values follow the state directly.
    always_comb begin
        wr_req  = (state == SEQ_TRANS) || (state == SEQ_NONTR);
        wr_addr = wr_req ? MODE_ADDR : '0;
        wr_data = (state == SEQ_TRANS) ? MODE_TRANSP :
                  (state == SEQ_NONTR) ? MODE_NONTR : '0;
        done    = (state == SEQ_DONE);
    end

    // A pending write holds its data until acknowledged.
    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !load) |=> (wr_req && $stable(wr_data) && $stable(wr_addr)));
    // Done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !done);
    // Done and a request never overlap.
    assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && wr_req));
endmodule

// File: rtl/rptr_cap_limiter.sv
// Top: captures repeater capability bytes on a strobe, decodes presence
// and count, clamps lanes and rate, and runs the mode-write sequence.
// Assumes byte 0 revision, byte 1 rate limit, byte 2 count, byte 4 lanes.
module rptr_cap_limiter
    import rptr_pkg::*;
#(
    parameter int CAP_BYTES = 6,
    parameter int MAX_RPT   = 8,
    parameter int CNT_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_valid,
    input  logic [CAP_BYTES*BYTE_W-1:0] cap_bytes,
    input  logic [BYTE_W-1:0]           sink_lanes,
    input  logic [BYTE_W-1:0]           plat_lanes,
    input  logic [BYTE_W-1:0]           sink_rate,
    input  logic [BYTE_W-1:0]           plat_rate,
    input  logic                        wr_ack,
    output logic [CNT_W-1:0]            rptr_count,
    output logic [BYTE_W-1:0]           lane_cnt,
    output logic [BYTE_W-1:0]           rate_code,
    output logic                        warn,
    output logic [CAP_BYTES*BYTE_W-1:0] cap_out,
    output logic                        wr_req,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [BYTE_W-1:0]           wr_data,
    output logic                        seq_done
);
    localparam int REV_IDX  = 0;
    localparam int RATE_IDX = 1;
    localparam int CNT_IDX  = 2;
    localparam int LANE_IDX = 4;

    logic              present, bad_enc;
    logic [CNT_W-1:0]  count_d;
    logic [BYTE_W-1:0] lanes_d, rate_d;

    rptr_count_decode #(.MAX_RPT(MAX_RPT), .CNT_W(CNT_W)) u_dec (
        .rev_byte (cap_bytes[REV_IDX*BYTE_W +: BYTE_W]),
        .cnt_byte (cap_bytes[CNT_IDX*BYTE_W +: BYTE_W]),
        .present  (present),
        .count    (count_d),
        .bad_enc  (bad_enc)
    );

    rptr_link_clamp #(.W(BYTE_W)) u_clamp (
        .sink_lanes (sink_lanes),
        .plat_lanes (plat_lanes),
        .sink_rate  (sink_rate),
        .plat_rate  (plat_rate),
        .use_rptr   (count_d != '0),
        .rptr_lanes (cap_bytes[LANE_IDX*BYTE_W +: BYTE_W]),
        .rptr_rate  (cap_bytes[RATE_IDX*BYTE_W +: BYTE_W]),
        .lanes      (lanes_d),
        .rate_sel   (rate_d)
    );

    // Result registers, updated only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_count <= '0;
            lane_cnt   <= '0;
            rate_code  <= '0;
            warn       <= 1'b0;
            cap_out    <= '0;
        end else if (cap_valid) begin
            rptr_count <= count_d;
            lane_cnt   <= lanes_d;
            rate_code  <= rate_d;
            warn       <= bad_enc;
            cap_out    <= present ? cap_bytes : '0;
        end
    end

    rptr_mode_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cap_valid),
        .need_trans (present),
        .need_nontr (count_d != '0),
        .wr_ack     (wr_ack),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .done       (seq_done)
    );

    // A nonzero count implies a qualifying captured revision and count field.
    assert_count_needs_rev_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_count != '0) |-> (cap_out[REV_IDX*BYTE_W +: BYTE_W] >= MIN_REV &&
                                cap_out[CNT_IDX*BYTE_W +: BYTE_W] != '0));
    // Count never exceeds the repeater maximum.
    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rptr_count <= CNT_W'(MAX_RPT));
    // Warning and a decoded count are exclusive.
    assert_warn_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_count != '0) |-> !warn);
    // Rate is always a supported code or zero.
    assert_rate_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rate_code == 8'h00 || rate_code == 8'h06 || rate_code == 8'h0A || rate_code == 8'h14);
    // Results hold without a strobe.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> ($stable(rptr_count) && $stable(lane_cnt) &&
                        $stable(rate_code) && $stable(warn) && $stable(cap_out)));
endmodule

// File: tb/rptr_cap_limiter_bench.sv
// Scoreboard bench: driver pushes expected results, monitor compares on done.
module rptr_cap_limiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [47:0] cap_bytes = '0;
    logic [7:0]  sink_lanes = '0, plat_lanes = '0, sink_rate = '0, plat_rate = '0;
    logic        wr_ack = 1'b0;
    logic [3:0]  rptr_count;
    logic [7:0]  lane_cnt, rate_code, wr_data;
    logic        warn, wr_req, seq_done;
    logic [47:0] cap_out;
    logic [19:0] wr_addr;

    always #2 clk = ~clk;

    rptr_cap_limiter u_rptr_cap_limiter (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_bytes(cap_bytes),
        .sink_lanes(sink_lanes), .plat_lanes(plat_lanes), .sink_rate(sink_rate),
        .plat_rate(plat_rate), .wr_ack(wr_ack), .rptr_count(rptr_count),
        .lane_cnt(lane_cnt), .rate_code(rate_code), .warn(warn), .cap_out(cap_out),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .seq_done(seq_done)
    );

    typedef struct {
        logic [3:0]  cnt;
        logic [7:0]  lanes;
        logic [7:0]  rate;
        logic        warn;
        logic [47:0] cap;
        int          nwr;
        logic [7:0]  wd0;
        logic [7:0]  wd1;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;
    int   checks = 0, errors = 0;
    int   done_cnt = 0;
    int   ack_lat = 1;
    int   wait_ctr = 0;
    int   n_wr = 0;
    logic [7:0] wlog [2];
    logic prev_pending = 1'b0;
    logic [7:0] prev_data = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [47:0] b, input logic [7:0] sl, pl, sr, pr);
        exp_t e;
        logic [7:0] rev, cf, mx;
        logic pres;
        rev = b[7:0]; cf = b[23:16];
        pres = (rev >= 8'h14) && (cf != 0);
        e.cnt = 0;
        case (cf)
            8'h80: e.cnt = 1; 8'h40: e.cnt = 2; 8'h20: e.cnt = 3; 8'h10: e.cnt = 4;
            8'h08: e.cnt = 5; 8'h04: e.cnt = 6; 8'h02: e.cnt = 7; 8'h01: e.cnt = 8;
            default: e.cnt = 0;
        endcase
        if (!pres) e.cnt = 0;
        e.warn = pres && (e.cnt == 0);
        e.cap = pres ? b : 48'h0;
        e.lanes = (sl < pl) ? sl : pl;
        if (e.cnt != 0 && b[39:32] != 0 && b[39:32] < e.lanes) e.lanes = b[39:32];
        mx = (sr < pr) ? sr : pr;
        if (e.cnt != 0 && b[15:8] != 0 && b[15:8] < mx) mx = b[15:8];
        e.rate = (mx >= 8'h14) ? 8'h14 : (mx >= 8'h0A) ? 8'h0A : (mx >= 8'h06) ? 8'h06 : 8'h00;
        e.nwr = pres ? ((e.cnt != 0) ? 2 : 1) : 0;
        e.wd0 = 8'h55; e.wd1 = 8'hAA;
        return e;
    endfunction

    // Monitor: acks writes, logs them, checks hold, and scores on done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_pending) begin
                chk(wr_req && wr_data == prev_data, "R7", "data held until ack",
                    {56'h0, wr_data}, {56'h0, prev_data});
            end
            chk(!(wr_req && seq_done), "R7", "done with request", {63'h0, seq_done}, 64'h0);
            if (wr_req) begin
                if (wait_ctr >= ack_lat) begin
                    wr_ack = 1'b1;
                    wait_ctr = 0;
                    chk(wr_addr == 20'hF0003, "R4", "write address", {44'h0, wr_addr}, 64'hF0003);
                    if (n_wr < 2) wlog[n_wr] = wr_data;
                    n_wr++;
                    prev_pending = 1'b0;
                end else begin
                    wr_ack = 1'b0;
                    wait_ctr++;
                    prev_pending = 1'b1;
                    prev_data = wr_data;
                end
            end else begin
                wr_ack = 1'b0;
                wait_ctr = 0;
                prev_pending = 1'b0;
            end
            if (seq_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected done", 64'h1, 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    last_exp = e;
                    chk(rptr_count == e.cnt, "R2", "repeater count", {60'h0, rptr_count}, {60'h0, e.cnt});
                    chk(warn == e.warn, "R3", "warning flag", {63'h0, warn}, {63'h0, e.warn});
                    chk(cap_out == e.cap, "R1", "captured bytes", {16'h0, cap_out}, {16'h0, e.cap});
                    chk(lane_cnt == e.lanes, "R5", "lane count", {56'h0, lane_cnt}, {56'h0, e.lanes});
                    chk(rate_code == e.rate, "R6", "rate code", {56'h0, rate_code}, {56'h0, e.rate});
                    chk(n_wr == e.nwr, "R4", "write count", 64'(n_wr), 64'(e.nwr));
                    if (e.nwr >= 1 && n_wr >= 1)
                        chk(wlog[0] == e.wd0, "R4", "first write data", {56'h0, wlog[0]}, {56'h0, e.wd0});
                    if (e.nwr >= 2 && n_wr >= 2)
                        chk(wlog[1] == e.wd1, "R4", "second write data", {56'h0, wlog[1]}, {56'h0, e.wd1});
                end
                n_wr = 0;
                done_cnt++;
            end
        end
    end

    // Driver: push expected result, strobe, wait for the done pulse.
    task automatic run_tx(input logic [47:0] b, input logic [7:0] sl, pl, sr, pr, input int lat);
        int start;
        exp_q.push_back(model(b, sl, pl, sr, pr));
        ack_lat = lat;
        start = done_cnt;
        @(negedge clk);
        cap_bytes = b; sink_lanes = sl; plat_lanes = pl; sink_rate = sr; plat_rate = pr;
        cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
        for (int k = 0; k < 200 && done_cnt == start; k++) @(negedge clk);
        if (done_cnt == start) chk(1'b0, "R7", "done timeout", 64'h0, 64'h1);
    endtask

    function automatic logic [47:0] mk(input logic [7:0] rev, rt, cf, ln);
        return {8'h00, ln, 8'h00, cf, rt, rev};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(rptr_count == 0 && lane_cnt == 0 && rate_code == 0 && !warn && cap_out == 0,
            "R8", "reset outputs", {60'h0, rptr_count}, 64'h0);
        chk(!wr_req && !seq_done, "R8", "reset handshake", {63'h0, wr_req}, 64'h0);

        // R1 R4 R5 R6: one repeater, both limits clamp
        run_tx(mk(8'h14, 8'h0A, 8'h80, 8'h02), 8'd4, 8'd4, 8'h14, 8'h1E, 1);
        // R1: revision just below threshold, bytes cleared, no writes
        run_tx(mk(8'h13, 8'h06, 8'h40, 8'h01), 8'd4, 8'd2, 8'h1E, 8'h14, 2);
        // R1: good revision but zero count field
        run_tx(mk(8'h20, 8'h06, 8'h00, 8'h01), 8'd1, 8'd4, 8'h0A, 8'h14, 1);
        // R3: multi-bit count field, single write, no clamp
        run_tx(mk(8'h14, 8'h06, 8'h30, 8'h01), 8'd4, 8'd4, 8'h14, 8'h14, 3);
        // R3: all-ones count field
        run_tx(mk(8'h30, 8'h06, 8'hFF, 8'h01), 8'd2, 8'd4, 8'h0A, 8'h14, 1);
        // R2 each one-hot code; zero repeater limits on some
        for (int i = 0; i < 8; i++) begin
            logic [7:0] cf;
            cf = 8'h80 >> i;
            run_tx(mk(8'h14 + 8'(i), (i % 2 == 0) ? 8'h00 : 8'h0A, cf,
                      (i % 3 == 0) ? 8'h00 : 8'h01), 8'd4, 8'd4, 8'h14, 8'h14, 1 + (i % 3));
        end
        // R6 rate boundaries
        run_tx(mk(8'h14, 8'h08, 8'h80, 8'h00), 8'd4, 8'd4, 8'h14, 8'h14, 1);
        run_tx(mk(8'h14, 8'h05, 8'h80, 8'h00), 8'd4, 8'd4, 8'h14, 8'h14, 1);
        run_tx(mk(8'h14, 8'h13, 8'h80, 8'h00), 8'd4, 8'd4, 8'h14, 8'h14, 1);
        run_tx(mk(8'h00, 8'h00, 8'h00, 8'h00), 8'd4, 8'd4, 8'h09, 8'h14, 1);
        // R5: repeater lane limit above base does not raise it
        run_tx(mk(8'h14, 8'h14, 8'h01, 8'h04), 8'd2, 8'd1, 8'h14, 8'h14, 2);

        // R8: outputs hold without a strobe
        repeat (10) @(negedge clk);
        chk(rptr_count == last_exp.cnt && lane_cnt == last_exp.lanes &&
            rate_code == last_exp.rate && cap_out == last_exp.cap, "R8", "hold after done",
            {56'h0, lane_cnt}, {56'h0, last_exp.lanes});
        chk(exp_q.size() == 0, "R7", "scoreboard drained", 64'(exp_q.size()), 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule